// File: doc/BRIEF.md
# Flag Offset Register Access Port

This block holds the almost-empty and almost-full threshold offsets of a FIFO and lets them be loaded and read back through the FIFO's own data buses. A load strobe redirects traffic: with the strobe active, a write-enable cycle stores the input word into the next offset register, and a read-enable cycle puts the next offset register onto the output bus in place of the FIFO's data word. With the strobe inactive, the same enables pass through as FIFO memory write and read requests. The block owns the output data register, so offset read-back and FIFO reads share one output word.

Two independent one-bit pointers, one for writes and one for reads, alternate between the empty-offset register and the full-offset register. An access sequence can be broken off at any time and picks up at the next register. Each almost flag gets a valid indication, held low while its own threshold is being changed and for a short settling time afterwards. The downstream flag comparators can then ignore the flag while it is unstable. Protocol mistakes are ignored and reported on a one-cycle error pulse. These mistakes are back-to-back offset reads and an offset read colliding with an offset write.

All inputs are sampled on the rising edge of one clock. Both resets are synchronous and active low.

Top module: `flag_offset_port`

## Requirements
- R1: While master reset is low, on the next edge the empty offset takes parameter AE_DEF and the full offset takes AF_DEF. Both valid outputs go high, the output word and the error pulse go to zero, and both pointers point at the empty-offset register.
- R2: An edge with load strobe low and write enable low is an offset write. It stores data-in bits [OFS_W-1:0] into the register under the write pointer, which then advances. Successive offset writes go to the empty register, then the full register, then back to the empty register.
- R3: With the load strobe high, the fifo_wr output equals the inverse of the write enable. Both offsets stay unchanged and the write pointer holds, so the next offset write continues the sequence.
- R4: An accepted offset read puts the zero-extended register under the read pointer on the output word after the edge, and advances the read pointer. An offset read is an edge with load strobe low, read enable low and partial reset high. Successive reads return the empty offset, then the full offset, alternating. The read pointer never moves with offset writes.
- R5: With the load strobe high, the fifo_rd output equals the inverse of the read enable. A FIFO read edge loads fifo_q into the output word.
- R6: An offset read request on the edge right after an accepted offset read is ignored. The output word and the read pointer stay unchanged, and the error output is high for the cycle after that edge.
- R7: An offset write and an offset read request on the same edge are a collision. The write takes effect, the read is ignored with the output word unchanged, and the error output pulses for one cycle.
- R8: The empty-valid output is low after an edge that writes the empty offset. It returns high after the second following edge, unless another empty write intervenes.
- R9: The full-valid output is low from the edge that writes the empty offset. It stays low until two edges after the edge that writes the full offset.
- R10: With partial reset low, the output word is cleared and offset reads are not accepted. Offsets, valid outputs and both pointers are unchanged.
- R11: On an edge with no accepted read and partial reset high, the output word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| ld_n | input | 1 | Load strobe, active low: routes enables to the offset registers |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | DATA_W | Input data bus |
| fifo_q | input | DATA_W | Word from FIFO memory for the output register |
| dout | output | DATA_W | Output data word |
| fifo_wr | output | 1 | FIFO memory write request |
| fifo_rd | output | 1 | FIFO memory read request |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| ae_valid | output | 1 | Almost-empty offset settled |
| af_valid | output | 1 | Almost-full offset settled |
| proto_err | output | 1 | One-cycle pulse on an ignored offset read |

## Verification
The hardest states to reach are the interleaved ones. Examples are a read request that lands exactly one edge after an accepted offset read while a write to the empty register is also arriving, or a partial reset in the middle of a half-done read sequence. Uniform stimulus rarely strings these together with the pointers in the right phase. The stimulus holds the load strobe low about half the time, with both enables active often, so collisions and gap violations happen repeatedly at both pointer phases. Directed runs first walk through an interrupted write pass, a gap violation, a collision and a partial reset with known pointer positions.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import flagofs_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int DATA_W = 18,
  parameter logic [OFS_W-1:0] AE_DEF = '0,
  parameter logic [OFS_W-1:0] AF_DEF = '0
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  output logic              wr_ev,
  output ofs_sel_e          wr_sel,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              fifo_wr
);

  logic [OFS_W-1:0] wr_word;

  assign wr_ev   = !ld_n && !wen_n;
  assign fifo_wr = ld_n && !wen_n;
  assign wr_word = din[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wr_sel <= SEL_EMPTY;
      ae_ofs <= AE_DEF;
      af_ofs <= AF_DEF;
    end else if (wr_ev) begin
      if (wr_sel == SEL_EMPTY) ae_ofs <= wr_word;
      else                     af_ofs <= wr_word;
      wr_sel <= sel_next(wr_sel);
    end
  end

  // R2: an empty-register write lands in ae_ofs and leaves af_ofs alone
  assert_wr_empty_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    (wr_ev && wr_sel == SEL_EMPTY) |=> (ae_ofs == $past(din[OFS_W-1:0]) && $stable(af_ofs)));

  // R3: load strobe high never disturbs the offsets
  assert_ld_high_keeps_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import flagofs_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_n,
  input  logic              ren_n,
  input  logic              wr_ev,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] dout,
  output logic              fifo_rd,
  output logic              rd_ev,
  output ofs_sel_e          rd_sel,
  output logic              proto_err
);

  function automatic logic [DATA_W-1:0] widen(input logic [OFS_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[OFS_W-1:0] = v;
    return r;
  endfunction

  logic rd_req, rd_last, gap_hit, clash;

  assign rd_req  = !ld_n && !ren_n && prst_n;
  assign gap_hit = rd_req && rd_last;
  assign clash   = rd_req && wr_ev;
  assign rd_ev   = rd_req && !rd_last && !wr_ev;
  assign fifo_rd = ld_n && !ren_n;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rd_sel    <= SEL_EMPTY;
      rd_last   <= 1'b0;
      dout      <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= gap_hit || clash;
      rd_last   <= rd_ev;
      if (rd_ev) rd_sel <= sel_next(rd_sel);
      if (!prst_n)      dout <= '0;
      else if (rd_ev)   dout <= widen((rd_sel == SEL_EMPTY) ? ae_ofs : af_ofs);
      else if (fifo_rd) dout <= fifo_q;
    end
  end

  // R6: a request right after an accepted read raises the error pulse
  assert_gap_err_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_ev ##1 rd_req |=> proto_err);

  // R7: collision leaves the output word untouched and reports
  assert_clash_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (rd_req && wr_ev) |=> (proto_err && $stable(dout)));

  // R10: partial reset clears the output word
  assert_prst_clear_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (dout == '0));

  // R11: no read, no change
  assert_hold_R11: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !rd_ev && !fifo_rd) |=> $stable(dout));

endmodule

// File: rtl/ofs_flag_settle.sv
module ofs_flag_settle #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic load,
  input  logic clear,
  output logic valid
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE);

  logic          done;
  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      done <= 1'b1;
      age  <= CMAX;
    end else if (load) begin
      done <= 1'b1;
      age  <= '0;
    end else if (clear) begin
      done <= 1'b0;
      age  <= '0;
    end else if (age != CMAX) begin
      age <= age + 1'b1;
    end
  end

  assign valid = done && (age == CMAX);

endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port
  import flagofs_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int DATA_W = 18,
  parameter logic [OFS_W-1:0] AE_DEF = OFS_W'(7),
  parameter logic [OFS_W-1:0] AF_DEF = OFS_W'(7)
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] dout,
  output logic              fifo_wr,
  output logic              fifo_rd,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              ae_valid,
  output logic              af_valid,
  output logic              proto_err
);

  localparam int SETTLE = 2;

  logic     wr_ev, rd_ev;
  ofs_sel_e wr_sel, rd_sel;
  logic     ae_load, af_load;

  assign ae_load = wr_ev && (wr_sel == SEL_EMPTY);
  assign af_load = wr_ev && (wr_sel == SEL_FULL);

  ofs_wr_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk(clk), .mrst_n(mrst_n), .ld_n(ld_n), .wen_n(wen_n), .din(din),
    .wr_ev(wr_ev), .wr_sel(wr_sel), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .fifo_wr(fifo_wr)
  );

  ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .ren_n(ren_n),
    .wr_ev(wr_ev), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .fifo_q(fifo_q),
    .dout(dout), .fifo_rd(fifo_rd), .rd_ev(rd_ev), .rd_sel(rd_sel), .proto_err(proto_err)
  );

  ofs_flag_settle #(.SETTLE(SETTLE)) u_ae_settle (
    .clk(clk), .mrst_n(mrst_n), .load(ae_load), .clear(1'b0), .valid(ae_valid)
  );

  ofs_flag_settle #(.SETTLE(SETTLE)) u_af_settle (
    .clk(clk), .mrst_n(mrst_n), .load(af_load), .clear(ae_load), .valid(af_valid)
  );

  // R8: empty-valid drops after its own write and rises only three samples later
  assert_ae_drop_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    ae_load |=> !ae_valid);
  assert_ae_rise_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(ae_valid) |-> $past(ae_load, 3));

  // R9: full-valid drops when a new pass starts and rises after its own write settles
  assert_af_drop_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    ae_load |=> !af_valid);
  assert_af_rise_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(af_valid) |-> $past(af_load, 3));

  // R4: the read pointer ignores offset writes
  assert_rptr_indep_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    !rd_ev |=> $stable(rd_sel));

  // R10: partial reset alone moves no pointer
  assert_prst_ptr_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_n && !wr_ev) |=> ($stable(wr_sel) && $stable(rd_sel)));

endmodule

// File: tb/flag_offset_port_test.sv
module flag_offset_port_test;

  localparam int CLK_P  = 10;
  localparam int OFS_W  = 16;
  localparam int DATA_W = 18;
  localparam logic [OFS_W-1:0] AE_D = 16'h0007;
  localparam logic [OFS_W-1:0] AF_D = 16'h0007;

  logic clk = 1'b0;
  logic mrst_n, prst_n, ld_n, wen_n, ren_n;
  logic [DATA_W-1:0] din, fifo_q, dout;
  logic fifo_wr, fifo_rd, ae_valid, af_valid, proto_err;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  always #(CLK_P/2) clk = ~clk;

  flag_offset_port #(.OFS_W(OFS_W), .DATA_W(DATA_W), .AE_DEF(AE_D), .AF_DEF(AF_D)) uut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n),
    .din(din), .fifo_q(fifo_q), .dout(dout), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_valid(ae_valid), .af_valid(af_valid),
    .proto_err(proto_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model state
  logic [OFS_W-1:0]  m_ae, m_af;
  logic [DATA_W-1:0] m_dout;
  bit m_wp, m_rp, m_rdlast, m_err, m_afw;
  int m_ae_age, m_af_age;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int age_step(int a);
    return (a >= 3) ? 3 : a + 1;
  endfunction

  function automatic logic [DATA_W-1:0] zx(logic [OFS_W-1:0] v);
    return {{(DATA_W-OFS_W){1'b0}}, v};
  endfunction

  task automatic model_reset();
    m_ae = AE_D; m_af = AF_D; m_dout = '0;
    m_wp = 0; m_rp = 0; m_rdlast = 0; m_err = 0; m_afw = 1;
    m_ae_age = 3; m_af_age = 3;
  endtask

  task automatic step(bit p, bit l, bit w, bit r, logic [DATA_W-1:0] d, logic [DATA_W-1:0] q);
    bit wr, rq, fr, rd;
    string dtag, etag;
    @(negedge clk);
    prst_n = p; ld_n = l; wen_n = w; ren_n = r; din = d; fifo_q = q;
    #1;
    chk("R3", fifo_wr, l && !w);
    chk("R5", fifo_rd, l && !r);
    wr = !l && !w;
    rq = !l && !r && p;
    fr = l && !r;
    rd = rq && !m_rdlast && !wr;
    etag = (wr && rq) ? "R7" : "R6";
    m_err = (rq && m_rdlast) || (wr && rq);
    m_ae_age = age_step(m_ae_age);
    m_af_age = age_step(m_af_age);
    if (wr) begin
      if (!m_wp) begin m_ae = d[OFS_W-1:0]; m_ae_age = 0; m_afw = 0; end
      else       begin m_af = d[OFS_W-1:0]; m_af_age = 0; m_afw = 1; end
      m_wp = !m_wp;
    end
    if (!p)      begin m_dout = '0; dtag = "R10"; end
    else if (rd) begin m_dout = zx(m_rp ? m_af : m_ae); m_rp = !m_rp; dtag = "R4"; end
    else if (fr) begin m_dout = q; dtag = "R5"; end
    else         dtag = "R11";
    m_rdlast = rd;
    @(posedge clk);
    #1;
    chk("R2", ae_ofs, m_ae);
    chk("R2", af_ofs, m_af);
    chk(dtag, dout, m_dout);
    chk(etag, proto_err, m_err);
    chk("R8", ae_valid, m_ae_age >= 2);
    chk("R9", af_valid, m_afw && m_af_age >= 2);
  endtask

  task automatic idle();
    step(1, 1, 1, 1, '0, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd5150));
    mrst_n = 0; prst_n = 1; ld_n = 1; wen_n = 1; ren_n = 1; din = '0; fifo_q = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", ae_ofs, AE_D);
    chk("R1", af_ofs, AF_D);
    chk("R1", dout, 0);
    chk("R1", proto_err, 0);
    chk("R1", ae_valid, 1);
    chk("R1", af_valid, 1);
    @(negedge clk); mrst_n = 1;
    model_reset();

    // R2/R8/R9: write empty, interrupt with FIFO write (R3), then full
    step(1, 0, 0, 1, 18'h00123, '0);
    idle();
    step(1, 1, 0, 1, 18'h3ffff, '0);
    idle();
    step(1, 0, 0, 1, 18'h04567, '0);
    idle(); idle(); idle();
    // R4: read empty, gap violation R6, then read full
    step(1, 0, 1, 0, '0, '0);
    step(1, 0, 1, 0, '0, '0);
    idle();
    step(1, 0, 1, 0, '0, '0);
    idle();
    // R5: FIFO read
    step(1, 1, 1, 0, '0, 18'h2abcd);
    idle();
    // R7: collision
    step(1, 0, 0, 0, 18'h00bee, '0);
    idle();
    // R10: partial reset mid read sequence, pointers kept
    step(1, 0, 1, 0, '0, '0);
    step(0, 1, 1, 1, '0, '0);
    step(1, 0, 1, 0, '0, '0);
    idle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit p, l, w, r;
      p = ($urandom_range(0, 99) >= 3);
      l = ($urandom_range(0, 99) >= 50);
      w = ($urandom_range(0, 99) >= 40);
      r = ($urandom_range(0, 99) >= 50);
      step(p, l, w, r, DATA_W'($urandom), DATA_W'($urandom));
    end
    summary();
  end

endmodule